// File: doc/BRIEF.md
# Prescaled Byte SPI Master

This block is a single-channel SPI master that exchanges one byte per transfer. Software drives it through a small register window: a control register, a status register, a pin-control register, a prescaler, a transmit port and a receive port. A write to the transmit port launches an 8-bit full-duplex exchange. Data leaves most-significant bit first on the data-out line, and the byte that arrives on the data-in line is shifted in at the same time. When the last bit is in, the block sets a ready flag, raises its interrupt line and presents the received byte on the receive port.

The serial clock is derived from the peripheral clock. Each half period of the serial clock lasts prescaler+1 peripheral cycles, so the bit rate is the peripheral clock divided by 2×(prescaler+1). Clock polarity and clock phase are selectable. A clock-enable bit gates the serial clock: while it is clear the clock rests at its idle level and an exchange already launched holds its place. A write to the transmit port while an exchange is in progress is dropped, and a collision flag records it. A keep option in the pin-control register decides whether data-out is driven between transfers or released.

Register offsets on `bus_addr`: 0 control, 1 status, 2 pin control, 3 prescaler, 4 transmit, 5 receive. Control bits: bit 0 serial-clock enable, bit 1 polarity (1 = idle high), bit 2 phase (1 = launch on the leading edge, sample on the trailing edge), bit 3 master operation, bit 4 interrupt mode. Status bits: bit 0 ready, bit 1 collision. Pin-control bit 0 is keep. Reads return data on `bus_rdata` in the same cycle. Their side effects on the flags take place at the clock edge where `bus_rd` is high.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the control register reads 0x18 (master bit 3 and interrupt-mode bit 4 set, clock enable clear), the prescaler reads 0xFF, the status register reads 0x00, pin control reads 0x01 (keep set), `irq` is low and `sclk` is low.
- R2: With prescaler value P, every half period of `sclk` lasts P+1 clock cycles, and the ready flag rises exactly 16×(P+1) cycles after the clock edge that accepts the transmit write.
- R3: In all four polarity/phase settings, the byte written to offset 4 appears on `mosi` most-significant bit first, and the byte presented on `miso` can be read from offset 5 once the exchange ends. `sclk` idles at the level of control bit 1.
- R4: With control bit 2 clear, the first bit is on `mosi` before the first edge, `miso` is sampled on leading edges and `mosi` changes on trailing edges. With bit 2 set, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R5: Status bit 0 sets when an exchange completes. `irq` is high exactly while that bit is set and control bit 4 is set. With bit 4 clear, `irq` stays low.
- R6: The ready flag clears when a status read is followed by a receive read, or when a new transmit write is accepted. A receive read that follows no status read leaves the flag set.
- R7: A transmit write while an exchange is in progress sets status bit 1 and is discarded. The exchange in progress still sends its own byte and receives the incoming one, with unchanged timing.
- R8: A status read clears the collision flag.
- R9: While control bit 0 is clear, `sclk` stays at its idle level and a launched exchange does not advance. Setting the bit lets the exchange run to completion.
- R10: With pin-control bit 0 set, `mosi_oe` is always high. With it clear, `mosi_oe` is high only while an exchange is in progress.
- R11: With control bit 3 clear, a transmit write starts no exchange: `sclk` does not toggle and the ready flag stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (triggers read side effects) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register |
| irq | output | 1 | Transfer-complete interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench goes after the phase handling by exchanging different bytes in all four polarity/phase settings against a slave model that launches and samples on the edges the requirements name. A design that sampled on the wrong edge would return a byte shifted by one bit. The exact completion time and each half-period are counted at prescaler values 0 through 3 and at 255, which catches an off-by-one in the divider that would stretch or shorten every bit. A transmit write during an exchange must leave both the outgoing and incoming bytes intact and must set a flag that one status read clears. A design that reloaded the shifter would put the intruding byte on the wire. The bench also checks the two-step ready clear, a clock-enable pause and a transfer attempted with the master bit clear. Each of these catches a design that clears flags too early or lets the clock run when it should stay idle.

// File: rtl/spi_byte_pkg.sv
// Package: shared register offsets, bit positions and the control-word
// layout for the prescaled byte SPI master.
package spi_byte_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_PINS  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_DIV   = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_TXD   = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_RXD   = 3'd5;

    // Control word, packed so that field order matches bit positions 4..0.
    typedef struct packed {
        logic irq_mode;   // bit 4
        logic master;     // bit 3
        logic cpha;       // bit 2
        logic cpol;       // bit 1
        logic sck_en;     // bit 0
    } ctrl_t;

    localparam int    CTRL_W     = $bits(ctrl_t);
    localparam ctrl_t CTRL_RESET = '{irq_mode: 1'b1, master: 1'b1,
                                     cpha: 1'b0, cpol: 1'b0, sck_en: 1'b0};

endpackage

// File: rtl/spi_byte_divider.sv
// Module: half-period tick generator.
// Emits a one-cycle tick every presc+1 cycles while run is high. The count
// restarts from zero whenever run is low, so the first tick of a transfer
// always comes a full half period after the launch.
module spi_byte_divider #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);

    logic [PRESC_W-1:0] cnt_q;
    logic               at_end;

    assign at_end = (cnt_q == presc);
    assign tick   = run & at_end;

    // Count cycles inside the current half period, restart when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PRESC_W'(1);
        end
    end

endmodule

// File: rtl/spi_byte_shifter.sv
// Module: serial shift engine.
// Runs 2*DATA_W serial-clock edges per exchange, MSB first. With cpha=0 the
// first bit is placed at launch, leading edges sample and trailing edges
// launch. With cpha=1 leading edges launch and trailing edges sample.
// Assumes start is only asserted while busy is low and that cpol/cpha are
// held steady during an exchange.
module spi_byte_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              sck_en,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              sclk,
    output logic              mosi
);

    localparam int EDGES = 2 * DATA_W;
    localparam int EW    = $clog2(EDGES);
    localparam int MSB   = DATA_W - 1;

    logic              busy_q;
    logic              sclk_q;
    logic [EW-1:0]     edge_q;
    logic [DATA_W-1:0] shreg_q;
    logic              samp_q;
    logic              mosi_q;
    logic [DATA_W-1:0] rx_q;
    logic              leading;
    logic              last_edge;
    logic [DATA_W-1:0] shifted;

    assign leading   = ~edge_q[0];
    assign last_edge = (edge_q == EW'(EDGES - 1));
    assign shifted   = {shreg_q[MSB-1:0], (cpha ? miso : samp_q)};
    assign done      = busy_q & tick & last_edge;
    assign busy      = busy_q;
    assign rx_byte   = rx_q;
    assign mosi      = mosi_q;
    assign sclk      = (busy_q & sck_en) ? sclk_q : cpol;

    // Launch, shift and sample on divided clock edges; retire after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            sclk_q  <= 1'b0;
            edge_q  <= '0;
            shreg_q <= '0;
            samp_q  <= 1'b0;
            mosi_q  <= 1'b0;
            rx_q    <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            sclk_q  <= cpol;
            edge_q  <= '0;
            shreg_q <= tx_byte;
            if (!cpha) begin
                mosi_q <= tx_byte[MSB];
            end
        end else if (busy_q && tick) begin
            sclk_q <= ~sclk_q;
            edge_q <= edge_q + EW'(1);
            if (leading) begin
                if (cpha) begin
                    mosi_q <= shreg_q[MSB];
                end else begin
                    samp_q <= miso;
                end
            end else begin
                shreg_q <= shifted;
                if (!cpha && !last_edge) begin
                    mosi_q <= shreg_q[MSB-1];
                end
                if (last_edge) begin
                    rx_q   <= shifted;
                    busy_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/spi_byte_regs.sv
// Module: register window and status flags.
// Holds control, pin control and prescaler, decodes the transmit write into
// a start pulse or a collision, and keeps the ready/collision flags. Ready
// clears through a status read followed by a receive read, or by a new
// accepted transmit write. Reads are combinational; read side effects occur
// at the edge where bus_rd is high.
module spi_byte_regs
    import spi_byte_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               busy,
    input  logic               xfer_done,
    input  logic [DATA_W-1:0]  rx_byte,
    output ctrl_t              ctrl,
    output logic [PRESC_W-1:0] presc,
    output logic               keep,
    output logic               start,
    output logic               ready,
    output logic               collision,
    output logic               irq
);

    ctrl_t              ctrl_q;
    logic [PRESC_W-1:0] presc_q;
    logic               keep_q;
    logic               ready_q;
    logic               coll_q;
    logic               arm_q;
    logic               wr_tx;
    logic               rd_stat;
    logic               rd_rx;

    assign wr_tx   = bus_wr && (bus_addr == OFS_TXD);
    assign rd_stat = bus_rd && (bus_addr == OFS_STAT);
    assign rd_rx   = bus_rd && (bus_addr == OFS_RXD);
    assign start   = wr_tx && !busy && ctrl_q.master;

    assign ctrl      = ctrl_q;
    assign presc     = presc_q;
    assign keep      = keep_q;
    assign ready     = ready_q;
    assign collision = coll_q;
    assign irq       = ready_q & ctrl_q.irq_mode;

    // Software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RESET;
            presc_q <= '1;
            keep_q  <= 1'b1;
        end else if (bus_wr) begin
            if (bus_addr == OFS_CTRL) begin
                ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            end
            if (bus_addr == OFS_DIV) begin
                presc_q <= bus_wdata[PRESC_W-1:0];
            end
            if (bus_addr == OFS_PINS) begin
                keep_q <= bus_wdata[0];
            end
        end
    end

    // Ready flag and the status-read arm that enables its receive-read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            arm_q   <= 1'b0;
        end else if (xfer_done) begin
            ready_q <= 1'b1;
            arm_q   <= 1'b0;
        end else if (start || (rd_rx && arm_q)) begin
            ready_q <= 1'b0;
            arm_q   <= 1'b0;
        end else if (rd_stat && ready_q) begin
            arm_q <= 1'b1;
        end
    end

    // Collision flag: set by a transmit write mid-exchange, cleared by status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coll_q <= 1'b0;
        end else if (wr_tx && busy) begin
            coll_q <= 1'b1;
        end else if (rd_stat) begin
            coll_q <= 1'b0;
        end
    end

    // Read data multiplexer.
    always_comb begin
        unique case (bus_addr)
            OFS_CTRL: bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            OFS_STAT: bus_rdata = {{(DATA_W-2){1'b0}}, coll_q, ready_q};
            OFS_PINS: bus_rdata = {{(DATA_W-1){1'b0}}, keep_q};
            OFS_DIV:  bus_rdata = {{(DATA_W-PRESC_W){1'b0}}, presc_q};
            OFS_RXD:  bus_rdata = rx_byte;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_byte_master.sv
// Module: top of the prescaled byte SPI master.
// Joins the register window, the half-period divider and the shift engine.
// Assumes a single peripheral clock and a synchronous active-low reset;
// miso is assumed already synchronous to clk.
module spi_byte_master
    import spi_byte_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int PRESC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    output logic              mosi_oe,
    input  logic              miso
);

    ctrl_t              ctrl;
    logic [PRESC_W-1:0] presc;
    logic               keep;
    logic               start;
    logic               ready;
    logic               collision;
    logic               busy;
    logic               done;
    logic               tick;
    logic [DATA_W-1:0]  rx_byte;

    // Drive data-out when keep is chosen, otherwise only during an exchange.
    assign mosi_oe = keep | busy;

    spi_byte_regs #(.DATA_W(DATA_W), .PRESC_W(PRESC_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .xfer_done (done),
        .rx_byte   (rx_byte),
        .ctrl      (ctrl),
        .presc     (presc),
        .keep      (keep),
        .start     (start),
        .ready     (ready),
        .collision (collision),
        .irq       (irq)
    );

    spi_byte_divider #(.PRESC_W(PRESC_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy & ctrl.sck_en),
        .presc (presc),
        .tick  (tick)
    );

    spi_byte_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tx_byte (bus_wdata),
        .tick    (tick),
        .sck_en  (ctrl.sck_en),
        .cpol    (ctrl.cpol),
        .cpha    (ctrl.cpha),
        .miso    (miso),
        .busy    (busy),
        .done    (done),
        .rx_byte (rx_byte),
        .sclk    (sclk),
        .mosi    (mosi)
    );

endmodule

// File: rtl/spi_byte_master_chk.sv
// Module: property checker for spi_byte_master, attached through bind.
// Observes ports and the flags exchanged between the register window and
// the shift engine.
module spi_byte_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic       sclk,
    input logic       mosi_oe,
    input logic       irq,
    input logic       busy,
    input logic       ready,
    input logic       collision,
    input logic       keep,
    input logic       sck_en,
    input logic       cpol,
    input logic       master,
    input logic       irq_mode
);

    // R9
    sck_gated_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_en |-> (sclk == cpol));

    // R7
    busy_write_collides_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_addr == 3'd4) |=> collision);

    // R10
    keep_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        keep |-> mosi_oe);

    // R10
    released_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!keep && !busy) |-> !mosi_oe);

    // R5
    irq_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && irq_mode) |-> irq);

    // R6
    tx_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && master && bus_wr && bus_addr == 3'd4) |=> !ready);

    // R11
    no_start_without_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !master && bus_wr && bus_addr == 3'd4) |=> !busy);

endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .sclk      (sclk),
    .mosi_oe   (mosi_oe),
    .irq       (irq),
    .busy      (busy),
    .ready     (ready),
    .collision (collision),
    .keep      (keep),
    .sck_en    (ctrl.sck_en),
    .cpol      (ctrl.cpol),
    .master    (ctrl.master),
    .irq_mode  (ctrl.irq_mode)
);

// File: tb/spi_byte_master_bench.sv
// Bench: directed scenarios for spi_byte_master, one task each, with a
// behavioural SPI slave that launches and samples on the edges R4 defines.
module spi_byte_master_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       sclk;
    logic       mosi;
    logic       mosi_oe;
    logic       miso = 1'b0;

    int checks = 0;
    int errors = 0;

    // slave model state
    logic [7:0] slv_sh = 8'h00;
    logic [7:0] cap = 8'h00;
    logic       in_xfer = 1'b0;
    logic       m_cpol = 1'b0;
    logic       m_cpha = 1'b0;

    always #10 clk = ~clk;

    spi_byte_master u_spi_byte_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .sclk      (sclk),
        .mosi      (mosi),
        .mosi_oe   (mosi_oe),
        .miso      (miso)
    );

    // Slave: capture mosi on sampling edges, launch miso on launching edges.
    always @(sclk) begin
        if (in_xfer) begin
            if (sclk !== m_cpol) begin
                if (!m_cpha) cap = {cap[6:0], mosi};
                else begin
                    miso   = slv_sh[7];
                    slv_sh = {slv_sh[6:0], 1'b0};
                end
            end else begin
                if (!m_cpha) begin
                    slv_sh = {slv_sh[6:0], 1'b0};
                    miso   = slv_sh[7];
                end else cap = {cap[6:0], mosi};
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic count_toggles(input int cycles, output int toggles);
        logic prev;
        prev = sclk;
        toggles = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sclk !== prev) toggles++;
            prev = sclk;
        end
    endtask

    // R1: reset values
    task automatic t_reset();
        logic [7:0] d;
        check("R1 irq after reset", irq, 0);
        check("R1 sclk after reset", sclk, 0);
        check("R1 mosi_oe after reset", mosi_oe, 1);
        bus_read(3'd0, d); check("R1 control reset", d, 8'h18);
        bus_read(3'd3, d); check("R1 prescaler reset", d, 8'hFF);
        bus_read(3'd1, d); check("R1 status reset", d, 8'h00);
        bus_read(3'd2, d); check("R1 pin control reset", d, 8'h01);
    endtask

    // R2 R3 R4 R5 R6 R7 R8: one full exchange, optionally with a colliding write
    task automatic do_xfer(input logic pol, input logic pha, input logic [7:0] pre,
                           input logic [7:0] tx, input logic [7:0] slv, input int collide_at);
        logic [7:0] d;
        logic       prev;
        int         n, last;
        bit         half_bad;
        bus_write(3'd0, 8'h19 | {5'b0, pha, pol, 1'b0});
        bus_write(3'd3, pre);
        m_cpol = pol; m_cpha = pha; slv_sh = slv; cap = 8'h00;
        miso = pha ? 1'b0 : slv[7];
        in_xfer = 1'b1;
        @(negedge clk);
        bus_addr = 3'd4; bus_wdata = tx; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        n = 0; last = 0; half_bad = 0; prev = sclk;
        while (!irq && n < 20000) begin
            if (collide_at != 0 && n == collide_at) begin
                bus_addr = 3'd4; bus_wdata = ~tx; bus_wr = 1'b1;
            end else bus_wr = 1'b0;
            @(negedge clk);
            n++;
            if (sclk !== prev) begin
                if (n - last != int'(pre) + 1) half_bad = 1;
                last = n;
                prev = sclk;
            end
        end
        bus_wr = 1'b0;
        in_xfer = 1'b0;
        check($sformatf("R2 completion cycles pre=%0d", pre), n, 16 * (int'(pre) + 1));
        check($sformatf("R2 half period pre=%0d", pre), half_bad, 0);
        check($sformatf("R3 R4 mosi byte mode=%0d%0d", pol, pha), cap, tx);
        check("R3 sclk idle level", sclk, pol);
        check("R5 irq at completion", irq, 1);
        bus_read(3'd1, d);
        check(collide_at != 0 ? "R7 status after collision" : "R5 status ready",
              d, collide_at != 0 ? 8'h03 : 8'h01);
        bus_read(3'd5, d);
        check($sformatf("R3 R4 rx byte mode=%0d%0d", pol, pha), d, slv);
        bus_read(3'd1, d);
        check("R6 R8 status cleared", d, 8'h00);
        check("R6 irq cleared", irq, 0);
    endtask

    // R5 R6: interrupt masked, and ready cleared only by the proper sequences
    task automatic t_irq_mask();
        logic [7:0] d;
        bus_write(3'd0, 8'h09);
        bus_write(3'd3, 8'h00);
        bus_write(3'd4, 8'h3C);
        repeat (24) @(negedge clk);
        check("R5 irq masked", irq, 0);
        bus_read(3'd5, d);
        bus_read(3'd1, d);
        check("R6 rx read without status read keeps ready", d, 8'h01);
        bus_write(3'd4, 8'h5A);
        bus_read(3'd1, d);
        check("R6 transmit write clears ready", d, 8'h00);
        repeat (24) @(negedge clk);
        bus_read(3'd1, d);
        check("R5 ready after second exchange", d, 8'h01);
        bus_read(3'd5, d);
        bus_read(3'd1, d);
        check("R6 status then rx read clears ready", d, 8'h00);
    endtask

    // R9: clock enable gates the serial clock and holds the exchange
    task automatic t_gate();
        int tg, n;
        bus_write(3'd3, 8'h00);
        bus_write(3'd0, 8'h18);
        m_cpol = 0; m_cpha = 0; slv_sh = 8'h96; cap = 8'h00; miso = 1'b1;
        in_xfer = 1'b1;
        bus_write(3'd4, 8'hC3);
        count_toggles(40, tg);
        check("R9 sclk held while disabled", tg, 0);
        check("R9 no completion while disabled", irq, 0);
        bus_write(3'd0, 8'h19);
        n = 0;
        while (!irq && n < 200) begin @(negedge clk); n++; end
        in_xfer = 1'b0;
        check("R9 completes after enable", irq, 1);
        check("R9 byte after resume", cap, 8'hC3);
        begin
            logic [7:0] d;
            bus_read(3'd1, d);
            bus_read(3'd5, d);
            check("R9 rx after resume", d, 8'h96);
        end
    endtask

    // R10: data-out enable with and without keep
    task automatic t_keep();
        logic [7:0] d;
        bus_write(3'd0, 8'h19);
        bus_write(3'd2, 8'h00);
        @(negedge clk);
        check("R10 released when idle", mosi_oe, 0);
        bus_write(3'd4, 8'h81);
        repeat (3) @(negedge clk);
        check("R10 driven during exchange", mosi_oe, 1);
        repeat (20) @(negedge clk);
        check("R10 released after exchange", mosi_oe, 0);
        bus_write(3'd2, 8'h01);
        @(negedge clk);
        check("R10 keep drives when idle", mosi_oe, 1);
        bus_read(3'd1, d);
        bus_read(3'd5, d);
    endtask

    // R11: no exchange without the master bit
    task automatic t_no_master();
        logic [7:0] d;
        int tg;
        bus_write(3'd0, 8'h11);
        bus_write(3'd4, 8'hE7);
        count_toggles(40, tg);
        check("R11 sclk quiet without master", tg, 0);
        check("R11 irq quiet without master", irq, 0);
        bus_read(3'd1, d);
        check("R11 status clear without master", d, 8'h00);
    endtask

    // Watchdog: a hung run is a failure and still reports the summary.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R2 got hang exp finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        do_xfer(1'b0, 1'b0, 8'd0, 8'hA5, 8'h3C, 0);
        do_xfer(1'b0, 1'b1, 8'd1, 8'h96, 8'hE1, 0);
        do_xfer(1'b1, 1'b0, 8'd3, 8'h0F, 8'hB4, 0);
        do_xfer(1'b1, 1'b1, 8'd2, 8'h71, 8'h8E, 0);
        do_xfer(1'b0, 1'b0, 8'd3, 8'hD2, 8'h4B, 10);
        do_xfer(1'b0, 1'b1, 8'd255, 8'h5E, 8'hC9, 0);
        t_irq_mask();
        t_gate();
        t_keep();
        t_no_master();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule